// File: doc/BRIEF.md
# Partition Hot-Reset Trigger and Fan-Out

This block sits beside the link-training logic of one switch partition. It watches the partition's upstream port for the two events that start a hot reset: received training sets carrying the hot-reset indication, and a data-link-down report. A data-link-down report is ignored when it comes from the link entering the L2/L3 Ready state. When a valid trigger is seen, the block commands the upstream link-training state machine to its next state. The target is Hot Reset for a training-set trigger and Detect for a link-down trigger.

The same event is fanned out to the downstream switch ports that belong to the partition, selected by a membership mask. What each port receives depends on its state. A port whose link is up is told to transmit hot-reset training sets. A disabled port is told to go to Detect instead. Any other port is left alone. A software secondary-bus-reset request drives the same downstream fan-out without touching the upstream port.

All triggers are edge-detected, and every command is a single-cycle pulse. Downstream status bits are sampled in the same cycle as the trigger edge.

Top module: `hot_reset_fanout`

## Requirements
- R1: A rising edge on `rxHotResetTs` produces, one clock later, a one-cycle `upCmdValid` with `upCmdState` = 2'b10 (Hot Reset).
- R2: A rising edge on `dlDown` while `l23Entry` is low produces, one clock later, a one-cycle `upCmdValid` with `upCmdState` = 2'b01 (Detect).
- R3: A rising edge on `dlDown` while `l23Entry` is high produces no upstream command and no downstream command. A `dlDown` level that stays high after such an edge produces nothing later, even when `l23Entry` falls.
- R4: When `rxHotResetTs` and `dlDown` rise in the same cycle, the upstream command is Hot Reset (2'b10).
- R5: On any trigger, each port i that has `memberMask[i]`=1, `dsLinkUp[i]`=1 and `dsDisabled[i]`=0 pulses `dsSendHotReset[i]` one clock later.
- R6: On any trigger, each port i that has `memberMask[i]`=1 and `dsDisabled[i]`=1 pulses `dsGoDetect[i]` and never `dsSendHotReset[i]`. Disabled takes precedence over link-up. Neither output bit of a port is ever high together with the other.
- R7: A port that is not a member, or that is neither link-up nor disabled, receives no command.
- R8: A rising edge on `sbrReq` fans out to the member ports by the rules of R5 and R6, with no upstream command. With an empty membership mask it produces no command at all.
- R9: An input level held high yields exactly one event. A level that is already high when reset is released yields no event.
- R10: While `rstN` is low, all outputs are zero, and `upCmdState` is 2'b00 whenever `upCmdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxHotResetTs | input | 1 | Upstream port is receiving hot-reset training sets |
| dlDown | input | 1 | Upstream data link layer reports link down |
| l23Entry | input | 1 | Link-down is due to entry into L2/L3 Ready |
| sbrReq | input | 1 | Software secondary-bus-reset request |
| memberMask | input | NUM_DS | Downstream ports belonging to this partition |
| dsLinkUp | input | NUM_DS | Per-port link-up status |
| dsDisabled | input | NUM_DS | Per-port LTSSM-disabled status |
| upCmdValid | output | 1 | Upstream next-state command strobe |
| upCmdState | output | 2 | Upstream target: 01 Detect, 10 Hot Reset |
| dsSendHotReset | output | NUM_DS | Per-port pulse: transmit hot-reset training sets |
| dsGoDetect | output | NUM_DS | Per-port pulse: move to Detect |

## Verification
The fan-out is tried with each single trigger cause on its own. It is also tried with the training-set and link-down causes together, with the L2/L3 qualifier present alongside a training-set cause and alongside a link-down cause, and with a software request combined with a suppressed link-down. These patterns separate the upstream priority from the suppression rule. Mixed masks of link-up, disabled, idle, non-member and both-set ports show that each port's command comes from its own state and membership. An empty mask checks the secondary-bus-reset corner. Held levels, both during operation and across a reset release, show that only edges start events.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  typedef enum logic [1:0] {
    UP_NONE   = 2'b00,
    UP_DETECT = 2'b01,
    UP_HOTRST = 2'b10
  } upTarget_e;

  typedef struct packed {
    logic      fanOut;
    logic      upValid;
    upTarget_e upTarget;
  } hrfStrobe_t;

endpackage

// File: rtl/hrf_ctrl.sv
module hrf_ctrl
  import hrf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxHotResetTs,
  input  logic       dlDown,
  input  logic       l23Entry,
  input  logic       sbrReq,
  output hrfStrobe_t stb
);

  // Previous-level samples run through reset, so a level that is already
  // high at reset release is not seen as an edge.
  logic tsPrev, dlPrev, sbrPrev;

  always_ff @(posedge clk) begin
    tsPrev  <= rxHotResetTs;
    dlPrev  <= dlDown;
    sbrPrev <= sbrReq;
  end

  logic tsRise, dlRise, sbrRise;

  always_comb begin
    tsRise  = rxHotResetTs & ~tsPrev;
    dlRise  = dlDown & ~dlPrev & ~l23Entry;
    sbrRise = sbrReq & ~sbrPrev;

    stb.upValid  = rstN & (tsRise | dlRise);
    stb.fanOut   = rstN & (tsRise | dlRise | sbrRise);
    if (!rstN)       stb.upTarget = UP_NONE;
    else if (tsRise) stb.upTarget = UP_HOTRST;
    else if (dlRise) stb.upTarget = UP_DETECT;
    else             stb.upTarget = UP_NONE;
  end

  // R4: an upstream strobe always names a real target.
  a_r4_target_named: assert property (@(posedge clk) disable iff (!rstN)
    stb.upValid |-> (stb.upTarget != UP_NONE));

endmodule

// File: rtl/hrf_datapath.sv
module hrf_datapath
  import hrf_pkg::*;
#(
  parameter int NUM_DS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrfStrobe_t        stb,
  input  logic [NUM_DS-1:0] memberMask,
  input  logic [NUM_DS-1:0] dsLinkUp,
  input  logic [NUM_DS-1:0] dsDisabled,
  output logic              upCmdValid,
  output logic [1:0]        upCmdState,
  output logic [NUM_DS-1:0] dsSendHotReset,
  output logic [NUM_DS-1:0] dsGoDetect
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upCmdValid <= 1'b0;
      upCmdState <= UP_NONE;
    end else begin
      upCmdValid <= stb.upValid;
      upCmdState <= stb.upValid ? stb.upTarget : UP_NONE;
    end
  end

  for (genvar i = 0; i < NUM_DS; i++) begin : g_port
    logic hit;
    assign hit = stb.fanOut & memberMask[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dsSendHotReset[i] <= 1'b0;
        dsGoDetect[i]     <= 1'b0;
      end else begin
        dsSendHotReset[i] <= hit & dsLinkUp[i] & ~dsDisabled[i];
        dsGoDetect[i]     <= hit & dsDisabled[i];
      end
    end
  end

  // R6: a port never gets both commands at once.
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (dsSendHotReset & dsGoDetect) == '0);

  // R7: commands only reach ports that were members when the trigger was seen.
  a_r7_member_only: assert property (@(posedge clk) disable iff (!rstN)
    ((dsSendHotReset | dsGoDetect) & ~$past(memberMask)) == '0);

  // R10: the target is cleared whenever the strobe is low.
  a_r10_idle_state: assert property (@(posedge clk) disable iff (!rstN)
    !upCmdValid |-> (upCmdState == 2'b00));

endmodule

// File: rtl/hot_reset_fanout.sv
module hot_reset_fanout
  import hrf_pkg::*;
#(
  parameter int NUM_DS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxHotResetTs,
  input  logic              dlDown,
  input  logic              l23Entry,
  input  logic              sbrReq,
  input  logic [NUM_DS-1:0] memberMask,
  input  logic [NUM_DS-1:0] dsLinkUp,
  input  logic [NUM_DS-1:0] dsDisabled,
  output logic              upCmdValid,
  output logic [1:0]        upCmdState,
  output logic [NUM_DS-1:0] dsSendHotReset,
  output logic [NUM_DS-1:0] dsGoDetect
);

  hrfStrobe_t stb;

  hrf_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxHotResetTs (rxHotResetTs),
    .dlDown       (dlDown),
    .l23Entry     (l23Entry),
    .sbrReq       (sbrReq),
    .stb          (stb)
  );

  hrf_datapath #(.NUM_DS(NUM_DS)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .memberMask     (memberMask),
    .dsLinkUp       (dsLinkUp),
    .dsDisabled     (dsDisabled),
    .upCmdValid     (upCmdValid),
    .upCmdState     (upCmdState),
    .dsSendHotReset (dsSendHotReset),
    .dsGoDetect     (dsGoDetect)
  );

  // R1: a training-set edge commands Hot Reset on the next cycle.
  a_r1_ts_hot: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxHotResetTs) |=> (upCmdValid && upCmdState == 2'b10));

  // R2: an unqualified link-down edge, with no training-set edge, commands Detect.
  a_r2_dl_detect: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dlDown) && !l23Entry && !$rose(rxHotResetTs))
      |=> (upCmdValid && upCmdState == 2'b01));

  // R3: a link-down edge caused by L2/L3 entry produces no upstream command.
  a_r3_l23_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dlDown) && l23Entry && !$rose(rxHotResetTs)) |=> !upCmdValid);

  // R8: a software request alone leaves the upstream port untouched.
  a_r8_sbr_no_up: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sbrReq) && !$rose(rxHotResetTs) && !$rose(dlDown)) |=> !upCmdValid);

endmodule

// File: tb/hot_reset_fanout_tb_top.sv
`timescale 1ns/1ps
module hot_reset_fanout_tb_top;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxHotResetTs = 1'b0, dlDown = 1'b0, l23Entry = 1'b0, sbrReq = 1'b0;
  logic [N-1:0] memberMask = '0, dsLinkUp = '0, dsDisabled = '0;
  logic upCmdValid;
  logic [1:0] upCmdState;
  logic [N-1:0] dsSendHotReset, dsGoDetect;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hot_reset_fanout #(.NUM_DS(N)) dut_i (
    .clk(clk), .rstN(rstN), .rxHotResetTs(rxHotResetTs), .dlDown(dlDown),
    .l23Entry(l23Entry), .sbrReq(sbrReq), .memberMask(memberMask),
    .dsLinkUp(dsLinkUp), .dsDisabled(dsDisabled), .upCmdValid(upCmdValid),
    .upCmdState(upCmdState), .dsSendHotReset(dsSendHotReset),
    .dsGoDetect(dsGoDetect)
  );

  // Vector layout: [31]ts [30]dl [29]l23 [28]sbr [27:20]mask [19:12]linkUp
  // [11:4]disabled [3]expUpValid [2:1]expUpState [0]expFanOut
  localparam logic [31:0] VECS [9] = '{
    32'h8FF0F30D,  // R1 R5 R6: training sets, mixed ports
    32'h40F3344B,  // R2 R7: link-down, idle and non-member ports
    32'h6FFFF000,  // R3: link-down from L2/L3 entry
    32'hC3C1824D,  // R4: both causes together
    32'h1A5FF001,  // R8: software request, partial mask
    32'h100FF001,  // R8: software request, empty mask
    32'hAFF0F00D,  // R1: L2/L3 qualifier does not block training sets
    32'h70F050A1,  // R3 R8: suppressed link-down plus software request
    32'h8FFC080D   // R6: disabled wins over link-up
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearTriggers();
    rxHotResetTs = 1'b0; dlDown = 1'b0; l23Entry = 1'b0; sbrReq = 1'b0;
  endtask

  task automatic checkQuiet(input string req);
    check(req, "upValid", {31'd0, upCmdValid}, 32'd0);
    check(req, "ds", {16'd0, dsSendHotReset, dsGoDetect}, 32'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checkQuiet("R10");
    check("R10", "upState", {30'd0, upCmdState}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[k]) begin
      logic [31:0] v;
      logic [N-1:0] expSend, expDet;
      v = VECS[k];
      rxHotResetTs = v[31]; dlDown = v[30]; l23Entry = v[29]; sbrReq = v[28];
      memberMask = v[27:20]; dsLinkUp = v[19:12]; dsDisabled = v[11:4];
      expSend = v[0] ? (v[27:20] & v[19:12] & ~v[11:4]) : '0;
      expDet  = v[0] ? (v[27:20] & v[11:4]) : '0;
      @(negedge clk);
      check("R1-vector", "upValid", {31'd0, upCmdValid}, {31'd0, v[3]});
      check("R2 R4 vector", "upState", {30'd0, upCmdState}, {30'd0, v[2:1]});
      check("R5 R7 vector", "send", {24'd0, dsSendHotReset}, {24'd0, expSend});
      check("R6 R8 vector", "detect", {24'd0, dsGoDetect}, {24'd0, expDet});
      clearTriggers();
      @(negedge clk);
      checkQuiet("R9 pulse");
    end

    // R9: held training-set level fires once
    begin
      int pulses = 0;
      memberMask = 8'hFF; dsLinkUp = 8'hFF; dsDisabled = 8'h00;
      rxHotResetTs = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (upCmdValid) pulses++;
      end
      check("R9", "held-level pulses", pulses, 32'd1);
      clearTriggers();
      @(negedge clk);
    end

    // R3: L2/L3 link-down stays quiet even after the qualifier falls
    l23Entry = 1'b1; dlDown = 1'b1;
    @(negedge clk);
    checkQuiet("R3");
    l23Entry = 1'b0;
    @(negedge clk);
    checkQuiet("R3 held");
    @(negedge clk);
    checkQuiet("R3 held");
    clearTriggers();
    @(negedge clk);

    // R9: level already high across reset release
    rstN = 1'b0;
    sbrReq = 1'b1;
    rxHotResetTs = 1'b1;
    repeat (2) @(negedge clk);
    checkQuiet("R10 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkQuiet("R9 after reset");
    @(negedge clk);
    checkQuiet("R9 after reset");
    clearTriggers();
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule